// File: doc/BRIEF.md
# Up/Down Timer with Dual Compare Channels

This block is an 8-bit timer/counter for a peripheral subsystem. It advances on a selectable count source: stopped, one of five prescaler tick taps, or the falling or rising edge of an external pin. That pin passes through a two-flop synchroniser before edge detection. Four modes set the count sequence. The timer can count up to a fixed maximum or up to the value of compare channel A. It can also count up and then back down between zero and that turning value.

There are two compare channels, each with a CPU-written buffer and an active value. In the PWM modes the active value is reloaded from the buffer only when the count reaches its turning value. In the other modes a write takes effect at once. Compare matches and the overflow/bottom event each set a flag. Writing a 1 to a flag bit clears it. Each flag drives an interrupt request through its own mask bit. Each channel also drives a waveform pin.

Top module: `tmr8_updown_cmp`

## Requirements
- R1: After a synchronous active-low reset, the count, both compare buffers and actives, the control, flag and mask registers, the direction (up) and both waveform pins are all zero.
- R2: Control bits [2:0] select the count source. 000 freezes the count. Codes 001 to 101 advance it once on each cycle where tap bit (code-1) of `presc_tick` is high.
- R3: Code 111 advances the count on a rising edge of `ext_pin`, and 110 on a falling edge. A pin change seen at clock edge n moves the count at edge n+2.
- R4: Control bits [4:3] give the mode: 0 up to 0xFF, 1 up to compare A, 2 PWM-up to 0xFF, 3 PWM up/down with turning value compare A. In modes 0 to 2, a tick taken at TOP or at 0xFF wraps the count to 0 and sets the overflow flag (flag bit 0).
- R5: In mode 3 the count turns down on the tick taken at or above TOP. It turns up on the tick taken at 0 while counting down. That bottom tick sets the overflow flag.
- R6: Writes to addresses 2 (channel A) and 3 (channel B) always load the buffer. In modes 0 and 1 they also load the active value at the same edge. In modes 2 and 3 the active value takes the buffer only on a tick taken with the count equal to TOP.
- R7: A tick taken while the count equals a channel's active value sets that channel's flag (bit 1 for A, bit 2 for B).
- R8: Writing address 4 clears each flag bit whose data bit is 1. A set event in the same cycle wins over the clear.
- R9: Each interrupt output is high exactly when its flag bit and the same bit of the mask register (address 5) are both 1.
- R10: In modes 0 and 1 a match toggles the channel's waveform pin. In mode 2 an overflow sets it and otherwise a match clears it. In mode 3 a match clears it while counting up and sets it while counting down.
- R11: A write to address 1 loads the count. It takes precedence over a tick in that cycle, and that tick produces no events.
- R12: `bus_rdata` returns, combinationally, the register selected by `bus_addr`: 0 control, 1 count, 2 and 3 the buffers, 4 flags, 5 mask, and zero for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_tick | input | 5 | Prescaler tick taps, one per source code 1 to 5 |
| ext_pin | input | 1 | Asynchronous external count pin |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| flag_ovf | output | 1 | Overflow / bottom flag |
| flag_cmp_a | output | 1 | Compare A flag |
| flag_cmp_b | output | 1 | Compare B flag |
| irq_ovf | output | 1 | Masked overflow request |
| irq_cmp_a | output | 1 | Masked compare A request |
| irq_cmp_b | output | 1 | Masked compare B request |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |

## Verification
The embedded assertions check local rules on every cycle:
- a frozen count stays still;
- a wrap goes to zero;
- the direction flips at bottom;
- a count load wins;
- an active compare value holds outside its permitted update points;
- flags follow their set and clear events.

Only the bench's reference model can show the rest. That covers the sequence across modes, the delay of the buffered reload to TOP, the exact latency of the synchronised pin, the waveform pin rules, and the register read-back. It also covers the combined effect of random flag clears and count loads against running events.

// File: rtl/tmr_pkg.sv
// Shared types and register addresses for the up/down compare timer.
// Assumes a 3-bit source-select field and a 3-bit register address.
package tmr_pkg;
    localparam int CS_W  = 3;
    localparam int AW    = 3;
    localparam int NCH   = 2;
    localparam int NFLG  = NCH + 1;

    typedef enum logic [1:0] {
        MD_UP_MAX = 2'd0,
        MD_UP_CMP = 2'd1,
        MD_PWM_UP = 2'd2,
        MD_PWM_UD = 2'd3
    } tmr_mode_e;

    localparam logic [CS_W-1:0] CS_STOP = 3'd0;
    localparam logic [CS_W-1:0] CS_FALL = 3'd6;
    localparam logic [CS_W-1:0] CS_RISE = 3'd7;

    localparam logic [AW-1:0] RA_CTRL = 3'd0;
    localparam logic [AW-1:0] RA_CNT  = 3'd1;
    localparam logic [AW-1:0] RA_CMP0 = 3'd2;
    localparam logic [AW-1:0] RA_FLAG = 3'd4;
    localparam logic [AW-1:0] RA_MASK = 3'd5;
endpackage

// File: rtl/tmr_src_sel.sv
// Count-source selector: synchronises the external pin through two flops,
// detects its edges and picks one tick per cycle from the select code.
// Assumes NTAP prescaler taps occupy codes 1..NTAP.
module tmr_src_sel import tmr_pkg::*; #(
    parameter int NTAP = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CS_W-1:0] cs,
    input  logic [NTAP-1:0] taps,
    input  logic            ext_pin,
    output logic            tick
);
    logic meta_q, sync_q, last_q;
    logic rise_w, fall_w;

    // Two-flop synchroniser plus a delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= ext_pin;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise_w = sync_q & ~last_q;
    assign fall_w = ~sync_q & last_q;

    // Select the tick for the current source code
    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < NTAP; k++) begin
            if (cs == CS_W'(k + 1)) tick = taps[k];
        end
        if (cs == CS_RISE) tick = rise_w;
        if (cs == CS_FALL) tick = fall_w;
    end

    // R3
    rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs == CS_RISE && tick) |-> ($past(meta_q) && !$past(sync_q)));
endmodule

// File: rtl/tmr_count_unit.sv
// Bidirectional counter: sequences the count for the selected mode,
// reports TOP, and raises the overflow/bottom event on the qualifying tick.
// Assumes tick is already suppressed in a cycle with a CPU count load.
module tmr_count_unit import tmr_pkg::*; #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  tmr_mode_e     mode,
    input  logic [CW-1:0] top,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt,
    output logic          dir_dn,
    output logic          at_top,
    output logic          ovf_evt
);
    localparam logic [CW-1:0] MAXV = '1;
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_nx;
    logic          dn_nx;
    logic          ud, wrap;

    assign ud      = (mode == MD_PWM_UD);
    assign at_top  = (cnt == top);
    assign wrap    = at_top || (cnt == MAXV);
    assign ovf_evt = tick && (ud ? (dir_dn && cnt == '0) : wrap);

    // Next count and direction for load, up-only or up/down sequencing
    always_comb begin
        cnt_nx = cnt;
        dn_nx  = ud ? dir_dn : 1'b0;
        if (ld) begin
            cnt_nx = ld_val;
        end else if (tick) begin
            if (!ud) begin
                cnt_nx = wrap ? '0 : cnt + ONE;
            end else if (!dir_dn) begin
                if (cnt >= top) begin
                    dn_nx  = 1'b1;
                    cnt_nx = (cnt == '0) ? '0 : cnt - ONE;
                end else begin
                    cnt_nx = cnt + ONE;
                end
            end else begin
                if (cnt == '0) begin
                    dn_nx  = 1'b0;
                    cnt_nx = (top == '0) ? '0 : ONE;
                end else begin
                    cnt_nx = cnt - ONE;
                end
            end
        end
    end

    // Count and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_dn <= 1'b0;
        end else begin
            cnt    <= cnt_nx;
            dir_dn <= dn_nx;
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(cnt));
    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ud && cnt == top) |=> (cnt == '0));
    // R5
    bottom_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ud && dir_dn && cnt == '0) |=> !dir_dn);
    // R11
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/tmr_cmp_chan.sv
// One compare channel: CPU buffer, active compare value, match event and
// waveform pin. Assumes upd is a tick taken at TOP.
module tmr_cmp_chan import tmr_pkg::*; #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_mode_e     mode,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          tick,
    input  logic          upd,
    input  logic [CW-1:0] cnt,
    input  logic          dir_dn,
    input  logic          ovf_evt,
    output logic [CW-1:0] buf_q,
    output logic [CW-1:0] act_q,
    output logic          match_evt,
    output logic          wave
);
    logic pwm;

    assign pwm       = (mode == MD_PWM_UP) || (mode == MD_PWM_UD);
    assign match_evt = tick && (cnt == act_q);

    // Buffer takes every write; active follows the mode's update rule
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (wr) buf_q <= wdata;
            if (!pwm && wr)     act_q <= wdata;
            else if (pwm && upd) act_q <= buf_q;
        end
    end

    // Waveform pin update per mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else begin
            unique case (mode)
                MD_UP_MAX, MD_UP_CMP: if (match_evt) wave <= ~wave;
                MD_PWM_UP: begin
                    if (ovf_evt)        wave <= 1'b1;
                    else if (match_evt) wave <= 1'b0;
                end
                MD_PWM_UD: if (match_evt) wave <= dir_dn;
                default: wave <= wave;
            endcase
        end
    end

    // R6
    act_hold_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !upd) |=> $stable(act_q));
    // R6
    act_hold_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && !wr) |=> $stable(act_q));
endmodule

// File: rtl/tmr_flag_ctl.sv
// Flag register with write-one-to-clear and set priority, plus masking
// of each flag into its interrupt request.
module tmr_flag_ctl #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_evt,
    input  logic          clr_en,
    input  logic [NF-1:0] clr_bits,
    input  logic [NF-1:0] mask,
    output logic [NF-1:0] flag,
    output logic [NF-1:0] irq
);
    for (genvar i = 0; i < NF; i++) begin : g_bit
        // Per-bit flag: set wins over a same-cycle clear
        always_ff @(posedge clk) begin
            if (!rst_n)                      flag[i] <= 1'b0;
            else if (set_evt[i])             flag[i] <= 1'b1;
            else if (clr_en && clr_bits[i])  flag[i] <= 1'b0;
        end

        assign irq[i] = flag[i] & mask[i];

        // R7
        set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flag[i]);
        // R8
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_bits[i] && !set_evt[i]) |=> !flag[i]);
    end
endmodule

// File: rtl/tmr8_updown_cmp.sv
// Top of the up/down compare timer: register decode and read mux, source
// selection, counter, two compare channels and the flag block.
// Assumes a single-cycle write strobe and a combinational read port.
module tmr8_updown_cmp import tmr_pkg::*; #(
    parameter int CW   = 8,
    parameter int NTAP = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTAP-1:0] presc_tick,
    input  logic            ext_pin,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [CW-1:0]   bus_wdata,
    output logic [CW-1:0]   bus_rdata,
    output logic            flag_ovf,
    output logic            flag_cmp_a,
    output logic            flag_cmp_b,
    output logic            irq_ovf,
    output logic            irq_cmp_a,
    output logic            irq_cmp_b,
    output logic            wave_a,
    output logic            wave_b
);
    logic [CS_W-1:0] cs_q;
    tmr_mode_e       mode_q;
    logic [NFLG-1:0] mask_q;
    logic [NFLG-1:0] flags, irqs;
    logic            raw_tick, tick, ld;
    logic [CW-1:0]   cnt, top;
    logic            dir_dn, at_top, ovf_evt;
    logic [CW-1:0]   buf_v [NCH];
    logic [CW-1:0]   act_v [NCH];
    logic [NCH-1:0]  match_v, wave_v;
    logic [CW-1:0]   wdata_unused;

    assign wdata_unused = bus_wdata;
    assign ld   = bus_wr && (bus_addr == RA_CNT);
    assign tick = raw_tick && !ld;
    assign top  = (mode_q == MD_UP_CMP || mode_q == MD_PWM_UD) ? act_v[0] : '1;

    // Control and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= CS_STOP;
            mode_q <= MD_UP_MAX;
            mask_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == RA_CTRL) begin
                cs_q   <= bus_wdata[CS_W-1:0];
                mode_q <= tmr_mode_e'(bus_wdata[CS_W+1:CS_W]);
            end
            if (bus_addr == RA_MASK) mask_q <= bus_wdata[NFLG-1:0];
        end
    end

    // Register read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == RA_CTRL)      bus_rdata = CW'({mode_q, cs_q});
        else if (bus_addr == RA_CNT)  bus_rdata = cnt;
        else if (bus_addr == RA_FLAG) bus_rdata = CW'(flags);
        else if (bus_addr == RA_MASK) bus_rdata = CW'(mask_q);
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == RA_CMP0 + AW'(c)) bus_rdata = buf_v[c];
        end
    end

    tmr_src_sel #(.NTAP(NTAP)) u_src (
        .clk(clk), .rst_n(rst_n), .cs(cs_q), .taps(presc_tick),
        .ext_pin(ext_pin), .tick(raw_tick)
    );

    tmr_count_unit #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .top(top),
        .ld(ld), .ld_val(bus_wdata), .cnt(cnt), .dir_dn(dir_dn),
        .at_top(at_top), .ovf_evt(ovf_evt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        tmr_cmp_chan #(.CW(CW)) u_chan (
            .clk(clk), .rst_n(rst_n), .mode(mode_q),
            .wr(bus_wr && bus_addr == RA_CMP0 + AW'(c)),
            .wdata(bus_wdata), .tick(tick), .upd(tick && at_top),
            .cnt(cnt), .dir_dn(dir_dn), .ovf_evt(ovf_evt),
            .buf_q(buf_v[c]), .act_q(act_v[c]),
            .match_evt(match_v[c]), .wave(wave_v[c])
        );
    end

    tmr_flag_ctl #(.NF(NFLG)) u_flag (
        .clk(clk), .rst_n(rst_n), .set_evt({match_v, ovf_evt}),
        .clr_en(bus_wr && bus_addr == RA_FLAG),
        .clr_bits(bus_wdata[NFLG-1:0]), .mask(mask_q),
        .flag(flags), .irq(irqs)
    );

    assign flag_ovf   = flags[0];
    assign flag_cmp_a = flags[1];
    assign flag_cmp_b = flags[2];
    assign irq_ovf    = irqs[0];
    assign irq_cmp_a  = irqs[1];
    assign irq_cmp_b  = irqs[2];
    assign wave_a     = wave_v[0];
    assign wave_b     = wave_v[1];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && flags == '0 && !wave_a && !wave_b));
endmodule

// File: tb/sim_tmr8_updown_cmp.sv
module sim_tmr8_updown_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] presc_tick = '0;
    logic       ext_pin = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic flag_ovf, flag_cmp_a, flag_cmp_b, irq_ovf, irq_cmp_a, irq_cmp_b, wave_a, wave_b;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr8_updown_cmp u0 (
        .clk(clk), .rst_n(rst_n), .presc_tick(presc_tick), .ext_pin(ext_pin),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .flag_ovf(flag_ovf), .flag_cmp_a(flag_cmp_a),
        .flag_cmp_b(flag_cmp_b), .irq_ovf(irq_ovf), .irq_cmp_a(irq_cmp_a),
        .irq_cmp_b(irq_cmp_b), .wave_a(wave_a), .wave_b(wave_b)
    );

    // Behavioural reference state
    int m_cnt, m_dn, m_buf[2], m_act[2], m_fl, m_mask, m_cs, m_mode, m_wave[2];
    int pin_hist[$];

    task automatic chk(int act, int exp, string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_rd(int a);
        case (a)
            0: return m_mode * 8 + m_cs;
            1: return m_cnt;
            2: return m_buf[0];
            3: return m_buf[1];
            4: return m_fl;
            5: return m_mask;
            default: return 0;
        endcase
    endfunction

    // Reference model step on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_dn = 0; m_fl = 0; m_mask = 0; m_cs = 0; m_mode = 0;
            foreach (m_buf[i]) begin m_buf[i] = 0; m_act[i] = 0; m_wave[i] = 0; end
            pin_hist = '{0, 0, 0};
        end else begin
            int tk, ld, top, ovf, upd, wd, a, clr, pwm, ud, wrap, nc, nd;
            int mt[2];
            wd = bus_wdata; a = bus_addr;
            pwm = (m_mode >= 2); ud = (m_mode == 3);
            tk = 0;
            if (m_cs >= 1 && m_cs <= 5) tk = presc_tick[m_cs-1];
            if (m_cs == 7) tk = (pin_hist[1] == 1 && pin_hist[2] == 0);
            if (m_cs == 6) tk = (pin_hist[1] == 0 && pin_hist[2] == 1);
            ld = bus_wr && a == 1;
            if (ld) tk = 0;
            top = (m_mode == 1 || m_mode == 3) ? m_act[0] : 255;
            wrap = (m_cnt == top || m_cnt == 255);
            ovf = tk && (ud ? (m_dn && m_cnt == 0) : wrap);
            upd = tk && pwm && m_cnt == top;
            for (int c = 0; c < 2; c++) mt[c] = tk && (m_cnt == m_act[c]);
            nc = m_cnt; nd = ud ? m_dn : 0;
            if (ld) nc = wd;
            else if (tk) begin
                if (!ud) nc = wrap ? 0 : m_cnt + 1;
                else if (!m_dn) begin
                    if (m_cnt >= top) begin nd = 1; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
                    else nc = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin nd = 0; nc = (top == 0) ? 0 : 1; end
                    else nc = m_cnt - 1;
                end
            end
            for (int c = 0; c < 2; c++) begin
                if (m_mode <= 1) begin if (mt[c]) m_wave[c] = 1 - m_wave[c]; end
                else if (m_mode == 2) begin
                    if (ovf) m_wave[c] = 1; else if (mt[c]) m_wave[c] = 0;
                end else if (mt[c]) m_wave[c] = m_dn;
            end
            clr = (bus_wr && a == 4) ? (wd & 7) : 0;
            m_fl = (m_fl & ~clr) | (mt[1] * 4) | (mt[0] * 2) | ovf;
            for (int c = 0; c < 2; c++) begin
                if (bus_wr && a == 2 + c) begin
                    if (!pwm) m_act[c] = wd;
                end else if (upd) m_act[c] = m_buf[c];
                if (bus_wr && a == 2 + c && pwm && upd) m_act[c] = m_buf[c];
                if (bus_wr && a == 2 + c) m_buf[c] = wd;
            end
            if (bus_wr && a == 0) begin m_cs = wd & 7; m_mode = (wd >> 3) & 3; end
            if (bus_wr && a == 5) m_mask = wd & 7;
            m_cnt = nc; m_dn = nd;
            pin_hist.push_front(ext_pin);
            void'(pin_hist.pop_back());
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(flag_ovf, m_fl & 1, "R4 R5 R8");
            chk(flag_cmp_a, (m_fl >> 1) & 1, "R6 R7 R8");
            chk(flag_cmp_b, (m_fl >> 2) & 1, "R6 R7 R8");
            chk({irq_cmp_b, irq_cmp_a, irq_ovf}, m_fl & m_mask, "R9");
            chk(wave_a, m_wave[0], "R10");
            chk(wave_b, m_wave[1], "R10");
            chk(bus_rdata, exp_rd(bus_addr), "R12");
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk); #1 bus_wr = 1; bus_addr = 3'(a); bus_wdata = 8'(d);
        @(negedge clk); #1 bus_wr = 0; bus_addr = 3'd1;
    endtask

    task automatic rd_chk(int a, int exp, string req);
        @(negedge clk); #1 bus_addr = 3'(a);
        #1 chk(bus_rdata, exp, req);
        bus_addr = 3'd1;
    endtask

    // Random traffic: taps, pin, reads, flag clears and occasional count loads
    task automatic run(int n, bit loads);
        for (int i = 0; i < n; i++) begin
            int r;
            @(negedge clk); #1
            r = $urandom % 64;
            presc_tick = 5'($urandom);
            if ($urandom % 3 == 0) ext_pin = ~ext_pin;
            bus_wr = 0; bus_addr = 3'($urandom % 7);
            if (r < 4) begin bus_wr = 1; bus_addr = 3'd4; bus_wdata = 8'($urandom); end
            else if (r == 5 && loads) begin bus_wr = 1; bus_addr = 3'd1; bus_wdata = 8'($urandom); end
        end
        @(negedge clk); #1 bus_wr = 0; bus_addr = 3'd1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd_chk(1, 0, "R1"); rd_chk(0, 0, "R1"); rd_chk(2, 0, "R1");
        rd_chk(4, 0, "R1"); rd_chk(5, 0, "R1");
        chk({wave_a, wave_b}, 0, "R1");
        // R2 stopped source holds the count
        wr(1, 8'h37);
        run(30, 0);
        rd_chk(1, 8'h37, "R2");
        // Mode 0 on tap 1, masks on
        wr(5, 7); wr(2, 8'h40); wr(3, 8'hF0); wr(0, 8'h01);
        run(1500, 1);
        wr(0, 8'h03); run(800, 1);
        // Mode 1, TOP = compare A
        wr(2, 8'h20); wr(3, 8'h08); wr(0, 8'h0D);
        run(800, 1);
        // Mode 2, buffered reload
        wr(0, 8'h12); wr(2, 8'h80); wr(3, 8'h10);
        run(1000, 0);
        wr(2, 8'h30); rd_chk(2, 8'h30, "R6");
        run(1200, 1);
        // Mode 3 up/down
        wr(0, 8'h19); wr(2, 8'h30); wr(3, 8'h18);
        run(2000, 0);
        wr(2, 8'h00); run(300, 0);
        wr(2, 8'h50); run(1500, 1);
        // R3 external rising edge latency
        wr(0, 8'h07); ext_pin = 0; repeat (5) @(negedge clk);
        wr(1, 8'h10); repeat (4) @(negedge clk);
        #1 ext_pin = 1;
        @(posedge clk); @(posedge clk); #1 chk(bus_rdata, 8'h10, "R3");
        @(posedge clk); #1 chk(bus_rdata, 8'h11, "R3");
        run(600, 1);
        wr(0, 8'h06); run(600, 1);
        // R11 load beats a tick
        wr(0, 8'h01); presc_tick = 5'h1F;
        @(negedge clk); #1 bus_wr = 1; bus_addr = 3'd1; bus_wdata = 8'h80;
        @(negedge clk); chk(bus_rdata, 8'h80, "R11");
        #1 bus_wr = 0;
        @(negedge clk); chk(bus_rdata, 8'h81, "R11");
        // R8 set wins over clear: flag set on wrap while clearing
        wr(5, 0); wr(1, 8'hFE); c0 = 0;
        @(negedge clk); #1 bus_wr = 1; bus_addr = 3'd4; bus_wdata = 8'h07;
        @(negedge clk); #1 bus_wr = 0; bus_addr = 3'd1; c0 = flag_ovf;
        chk(c0, 1, "R8");
        run(100, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule